// File: doc/BRIEF.md
# Snapshot Microsecond Timestamp Counter

A free-running time base for measuring short software intervals. A prescaler turns the reference clock into a one-microsecond count enable. Four equal counter stages are chained so that each stage steps when the one below it rolls over, which gives one wide count. A host freezes the whole count into a holding register with a single command byte. It then fetches the frozen value one byte per read strobe through an 8-bit port. An internal byte pointer walks the value from the least significant byte upward.

A port-select input chooses between the command port and the data port. Two further commands pick how the count advances. One is a plain binary count. The other is a split form: the lower half holds microseconds and wraps once per second, and the upper half holds seconds. Each of the two mode commands restarts the time base from zero. A save command always puts the byte pointer back to the first byte. A reader that was part-way through a value and was interrupted by another save therefore continues from the wrong byte. Host software has to allow for this.

Top module: `snap_timer`

## Requirements
- R1: While rst_ni is low, the prescaler, all counter stages, the holding register and the byte pointer clear, and the mode becomes binary. After reset, rdata_o reads 0 and both bytes of the held value read 0.
- R2: The count advances once every DIV clock cycles (default 4). After a mode command, a save command issued k clocks later captures floor((k-1)/DIV) in binary mode.
- R3: In binary mode the four STAGE_W-bit stages form one count with stage 0 as the least significant. A stage steps exactly when every stage below it rolls over, and the whole count wraps to 0.
- R4: The save command is byte 8'h10, written with sel_cmd_i=1 and wr_i=1. It copies all stages into the holding register on the same edge, using the count as it stood before that edge, including a carry that ripples through several stages at that instant.
- R5: The holding register keeps its value while the count runs on, until the next save command.
- R6: A data read is rd_i=1 with sel_cmd_i=0. rdata_o shows the held byte selected by the pointer, and the pointer advances by one at the clock edge of the read. Byte 0 is bits 7:0 of the held value.
- R7: After the most significant byte is read, the pointer wraps back to byte 0.
- R8: A save command returns the pointer to byte 0.
- R9: Command 8'h20 selects binary mode and command 8'h21 selects seconds/microseconds mode. Each clears the prescaler and all stages on the same edge. Neither changes the holding register or the pointer.
- R10: In seconds/microseconds mode the lower two stages count microseconds from 0 to US_PER_SEC-1 and then return to 0. At that return the upper two stages, which hold seconds, increment. The held value is {seconds, microseconds}.
- R11: A command byte other than 8'h10, 8'h20 or 8'h21, and any write to the data port, have no effect. The holding register, pointer, mode and count all continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (4 MHz nominal) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_cmd_i | input | 1 | Port select: 1 = command port, 0 = data port |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Written byte |
| rdata_o | output | 8 | Held byte at the current pointer |

## Verification
The hardest situations to reach from the ports are the carries between stages and the seconds rollover. At the default widths these are millions of cycles away. The bench therefore builds the block with 4-bit stages and a short second of 50 microseconds, while keeping the divide-by-four prescaler. With these values every stage boundary, including the ripple from 0x0FFF to 0x1000 and the carry of the seconds field across its stage boundary, falls within a few thousand to about sixteen thousand cycles. Each table vector restarts the count with a mode command and saves it after a chosen number of cycles, so the value expected at each boundary follows directly from the cycle count.

// File: rtl/snap_tmr_pkg.sv
package snap_tmr_pkg;

  localparam int unsigned STAGES = 4;

  localparam logic [7:0] CMD_SAVE  = 8'h10;
  localparam logic [7:0] CMD_BIN   = 8'h20;
  localparam logic [7:0] CMD_SECUS = 8'h21;

  typedef enum logic {
    MODE_BIN   = 1'b0,
    MODE_SECUS = 1'b1
  } tmr_mode_e;

  typedef struct packed {
    logic save;
    logic set_bin;
    logic set_secus;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [7:0] b);
    cmd_dec_t d;
    d.save      = (b == CMD_SAVE);
    d.set_bin   = (b == CMD_BIN);
    d.set_secus = (b == CMD_SECUS);
    return d;
  endfunction

endpackage

// File: rtl/snap_tmr_prescale.sv
module snap_tmr_prescale #(
  parameter int unsigned DIV   = 4,
  parameter int unsigned PRE_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);

  logic [PRE_W-1:0] cnt_q;

  assign tick_o = (cnt_q == PRE_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  if (DIV > 1) begin : g_spacing
    // R2
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end

endmodule

// File: rtl/snap_tmr_stage.sv
module snap_tmr_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wrap_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);

  logic [W-1:0] q_q;

  assign q_o     = q_q;
  assign carry_o = inc_i & (&q_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_q <= '0;
    else if (clr_i || wrap_i) q_q <= '0;
    else if (inc_i)           q_q <= q_q + 1'b1;
  end

  // R3
  stage_rollover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && !clr_i && !wrap_i) |=> (q_o == '0));

endmodule

// File: rtl/snap_tmr_hold.sv
module snap_tmr_hold #(
  parameter int unsigned TOTAL_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               save_i,
  input  logic [TOTAL_W-1:0] val_i,
  input  logic               adv_i,
  output logic [7:0]         byte_o,
  output logic [TOTAL_W-1:0] snap_o
);

  localparam int unsigned BYTES = TOTAL_W / 8;
  localparam int unsigned PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [TOTAL_W-1:0] hold_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [7:0]         byte_w [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_w[b] = hold_q[8*b +: 8];
  end

  assign byte_o = byte_w[ptr_q];
  assign snap_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      ptr_q  <= '0;
    end else if (save_i) begin
      hold_q <= val_i;
      ptr_q  <= '0;
    end else if (adv_i) begin
      ptr_q <= (ptr_q == PTR_W'(BYTES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // R8
  save_ptr_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> (ptr_q == '0));

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !save_i |=> $stable(hold_q));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !save_i && ptr_q == PTR_W'(BYTES - 1)) |=> (ptr_q == '0));

endmodule

// File: rtl/snap_timer.sv
module snap_timer
  import snap_tmr_pkg::*;
#(
  parameter int unsigned DIV        = 4,
  parameter int unsigned PRE_W      = 16,
  parameter int unsigned STAGE_W    = 16,
  parameter int unsigned US_PER_SEC = 1000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_cmd_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);

  localparam int unsigned TOTAL_W = STAGES * STAGE_W;
  localparam int unsigned HALF_W  = TOTAL_W / 2;

  logic                          cmd_wr;
  cmd_dec_t                      dec;
  logic                          save_cmd, clr_cmd;
  tmr_mode_e                     mode_q;
  logic                          tick, us_wrap, secus;
  logic [STAGES-1:0][STAGE_W-1:0] stage_q;
  logic [STAGES-1:0]             carry;
  logic [TOTAL_W-1:0]            count, snap;
  logic [HALF_W-1:0]             usec;

  assign cmd_wr   = wr_i & sel_cmd_i;
  assign dec      = decode_cmd(wdata_i);
  assign save_cmd = cmd_wr & dec.save;
  assign clr_cmd  = cmd_wr & (dec.set_bin | dec.set_secus);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mode_q <= MODE_BIN;
    else if (cmd_wr && dec.set_secus) mode_q <= MODE_SECUS;
    else if (cmd_wr && dec.set_bin)   mode_q <= MODE_BIN;
  end

  assign secus   = (mode_q == MODE_SECUS);
  assign count   = stage_q;
  assign usec    = count[HALF_W-1:0];
  assign us_wrap = secus & tick & (usec == HALF_W'(US_PER_SEC - 1));

  snap_tmr_prescale #(.DIV(DIV), .PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_cmd),
    .tick_o (tick)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic inc_s, wrap_s;
    if (s == 0) begin : g_inc0
      assign inc_s = tick;
    end else if (s == STAGES / 2) begin : g_incmid
      assign inc_s = secus ? us_wrap : carry[s-1];
    end else begin : g_incn
      assign inc_s = carry[s-1];
    end
    if (s < STAGES / 2) begin : g_wrap_lo
      assign wrap_s = us_wrap;
    end else begin : g_wrap_hi
      assign wrap_s = 1'b0;
    end
    snap_tmr_stage #(.W(STAGE_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_cmd),
      .wrap_i  (wrap_s),
      .inc_i   (inc_s),
      .q_o     (stage_q[s]),
      .carry_o (carry[s])
    );
  end

  snap_tmr_hold #(.TOTAL_W(TOTAL_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .save_i (save_cmd),
    .val_i  (count),
    .adv_i  (rd_i & ~sel_cmd_i),
    .byte_o (rdata_o),
    .snap_o (snap)
  );

  // R4
  save_atomic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_cmd |=> (snap == $past(count)));

  // R9
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> (count == '0));

  // R10
  usec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secus |-> (usec < HALF_W'(US_PER_SEC)));

  // R3
  full_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry[STAGES-1] && !secus && !clr_cmd) |=> (count == '0));

  // R11
  unknown_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !dec.save && !dec.set_bin && !dec.set_secus) |=> $stable(mode_q));

endmodule

// File: tb/tb_snap_timer.sv
module tb_snap_timer;

  localparam int unsigned DIV   = 4;
  localparam int unsigned SW    = 4;
  localparam int unsigned USPS  = 50;
  localparam int unsigned NV    = 17;

  typedef struct packed {
    logic        secus;
    int unsigned k;
    logic [15:0] exp;
  } vec_t;

  // k = clocks from mode command to save command; exp = expected held value
  localparam vec_t VECS [NV] = '{
    '{1'b0,     1, 16'h0000}, '{1'b0,     2, 16'h0000},
    '{1'b0,     4, 16'h0000}, '{1'b0,     5, 16'h0001},
    '{1'b0,     8, 16'h0001}, '{1'b0,     9, 16'h0002},
    '{1'b0,    61, 16'h000F}, '{1'b0,    65, 16'h0010},
    '{1'b0,  1025, 16'h0100}, '{1'b0,  1029, 16'h0101},
    '{1'b0, 16381, 16'h0FFF}, '{1'b0, 16385, 16'h1000},
    '{1'b1,   197, 16'h0031}, '{1'b1,   201, 16'h0100},
    '{1'b1,  3197, 16'h0F31}, '{1'b1,  3201, 16'h1000},
    '{1'b1,  3405, 16'h1101}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_cmd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  snap_timer #(.DIV(DIV), .PRE_W(16), .STAGE_W(SW), .US_PER_SEC(USPS)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_cmd_i (sel_cmd_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; takes effect on the next posedge
  task automatic cmd(input logic [7:0] c, input logic to_cmd = 1'b1);
    sel_cmd_i = to_cmd;
    wr_i      = 1'b1;
    wdata_i   = c;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i      = 1'b0;
    sel_cmd_i = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    sel_cmd_i = 1'b0;
    rd_i      = 1'b1;
    #1 b = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd_byte(lo);
    rd_byte(hi);
    w = {hi, lo};
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  b;
    int unsigned t0, ts;

    repeat (3) @(negedge clk_i);
    check("R1 rdata in reset", {8'h00, rdata_o}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_word(w);
    check("R1 held value after reset", w, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      cmd(VECS[i].secus ? 8'h21 : 8'h20);
      repeat (VECS[i].k - 1) @(negedge clk_i);
      cmd(8'h10);
      repeat (7) @(negedge clk_i);
      rd_word(w);
      if (VECS[i].secus)
        check($sformatf("R9 R10 R4 R5 R6 vec%0d", i), w, VECS[i].exp);
      else
        check($sformatf("R2 R3 R4 R5 R6 vec%0d", i), w, VECS[i].exp);
    end

    // R7: third read after a full word wraps to byte 0 (last held 0x1101)
    rd_byte(b);
    check("R7 pointer wrap", {8'h00, b}, 16'h0001);

    // R8 and R6
    cmd(8'h20);
    t0 = cyc;
    repeat (40) @(negedge clk_i);
    ts = cyc + 1;
    cmd(8'h10);
    rd_byte(b);
    check("R6 first byte LSB", {8'h00, b}, 16'((ts - t0 - 1) / DIV));
    repeat (40) @(negedge clk_i);
    ts = cyc + 1;
    cmd(8'h10);
    rd_byte(b);
    check("R8 save resets pointer", {8'h00, b}, 16'(((ts - t0 - 1) / DIV) & 8'hFF));

    // R11: pointer now at byte 1; bogus commands and data-port write
    cmd(8'hFF);
    cmd(8'h11);
    cmd(8'h5A, 1'b0);
    rd_byte(b);
    check("R11 pointer kept", {8'h00, b}, 16'(((ts - t0 - 1) / DIV) >> 8));
    rd_byte(b);
    check("R11 held value kept", {8'h00, b}, 16'(((ts - t0 - 1) / DIV) & 8'hFF));
    repeat (25) @(negedge clk_i);
    ts = cyc + 1;
    cmd(8'h10);
    rd_word(w);
    check("R11 count and mode kept", w, 16'((ts - t0 - 1) / DIV));

    // R9: mode command leaves held value and pointer alone
    rd_byte(b);
    cmd(8'h21);
    rd_byte(b);
    check("R9 mode cmd keeps pointer", {8'h00, b}, 16'(((ts - t0 - 1) / DIV) >> 8));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule